// File: doc/BRIEF.md
# Single-Line Transient Fault Injector

This block sits in series on one signal wire of a simulated processor system, between the wire's driver and its receiver. While it is not armed, it is a plain wire. The output follows the input through combinational logic only, so it adds no register and no delay. When armed, it waits a fixed boot interval plus a pseudo-random offset. It then takes over the wire for a short burst and drives a programmed serial bit pattern that stands in for the logic-level image of an induced transient, such as a decaying 1 MHz ringing.

The random offset spans one full pass of the monitored program loop. A fault campaign that runs many events with different seeds therefore hits every point of the loop with equal likelihood. The burst either overrides the wire value or is XORed onto it, selected per event. Each arm produces exactly one event. Only one wire is ever touched.

Top module: `line_fault_injector`

## Requirements
- R1: With `injActive` low, `lineOut` equals `lineIn` in the same time step, with no clock edge in between.
- R2: `lineOut` keeps following `lineIn` while an armed event is still waiting and after the event has finished.
- R3: Let E0 be the first rising edge at which `armEn` is sampled high while idle and seeded. `injActive` rises right after edge E0 + BOOT_TICKS + (L mod SPAN), where BOOT_TICKS = BOOT_NS/CLK_NS (1625 by default), SPAN = WINDOW_NS/CLK_NS + 1 (3751 by default), and L is the generator state at E0.
- R4: The generator is loaded from `seed` on the first edge after reset, with a zero seed replaced by 1. Each accepted arm uses the current state and then advances it one step: next = (s >> 1) XOR (s[0] ? 16'hB400 : 0).
- R5: A burst lasts `patLen` + 1 clock cycles. Cycle i of the burst uses bit i of `patWord`, least significant bit first.
- R6: With `modeForce` = 1, `lineOut` equals the pattern bit during the burst. With `modeForce` = 0, it equals `lineIn` XOR the pattern bit.
- R7: `patWord`, `patLen` and `modeForce` are captured at E0. Changes to them after E0 have no effect on the event.
- R8: `injDone` rises in the cycle after the last burst cycle and stays high, with no further burst, for as long as `armEn` stays high.
- R9: A low `armEn` at a clock edge clears `injDone` and returns the block to idle, where a new arm is accepted. Dropping `armEn` before the burst ends cancels the event without setting `injDone`.
- R10: While reset is asserted, `injActive` and `injDone` are 0 and `lineOut` follows `lineIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Wire value from the upstream driver |
| armEn | input | 1 | Arm request; held high for one event, low to re-arm or cancel |
| modeForce | input | 1 | 1 overrides the wire, 0 XORs the pattern onto it |
| patWord | input | 2**LEN_W | Serial pattern, LSB sent first |
| patLen | input | LEN_W | Burst length minus one |
| seed | input | 16 | Start value of the offset generator |
| lineOut | output | 1 | Wire value to the downstream receiver |
| injActive | output | 1 | High during burst cycles |
| injDone | output | 1 | Event finished, held until `armEn` drops |

## Verification
A wrong wait count shows as a shift of the rising `injActive` edge relative to E0 plus the boot interval and offset. That shift is visible to the exact cycle on the first event after reset, since the seed fixes the offset. A generator that steps wrongly shows only on the second event, as a different start cycle. A broken pattern shift or length counter corrupts `lineOut` within the burst, or moves the fall of `injActive` and the rise of `injDone` by whole cycles. A register wrongly placed in the pass-through path shows immediately as `lineOut` lagging `lineIn` while idle.

// File: rtl/lfi_pkg.sv
package lfi_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_INJ,
    ST_DONE
  } lfi_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch pattern and mode
    logic shift;    // advance to next pattern bit
    logic active;   // burst drives the wire
  } lfi_strobe_t;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {1'b0, s[LFSR_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
  endfunction

endpackage

// File: rtl/lfi_ctrl.sv
module lfi_ctrl
  import lfi_pkg::*;
#(
  parameter int BOOT_TICKS = 1625,
  parameter int SPAN       = 3751,
  parameter int LEN_W      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                armEn,
  input  logic [LFSR_W-1:0]   seed,
  input  logic [LEN_W-1:0]    patLen,
  output lfi_strobe_t         strobe,
  output logic                injActive,
  output logic                injDone
);

  localparam int CNT_W = $clog2(BOOT_TICKS + SPAN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BOOT_TICKS + SPAN - 2);

  lfi_state_e        state;
  logic [CNT_W-1:0]  waitCnt;
  logic [LEN_W-1:0]  lenCnt;
  logic [LFSR_W-1:0] lfsr;
  logic              seeded;
  logic              armTake;
  logic [CNT_W-1:0]  waitLoad;
  logic [LFSR_W-1:0] offsetRaw;

  assign armTake   = (state == ST_IDLE) && armEn && seeded;
  assign offsetRaw = lfsr % LFSR_W'(SPAN);
  assign waitLoad  = CNT_W'(BOOT_TICKS - 1) + CNT_W'(offsetRaw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      lenCnt  <= '0;
      lfsr    <= '0;
      seeded  <= 1'b0;
    end else begin
      if (!seeded) begin
        lfsr   <= (seed == '0) ? LFSR_W'(1) : seed;
        seeded <= 1'b1;
      end
      unique case (state)
        ST_IDLE: if (armTake) begin
          state   <= ST_WAIT;
          waitCnt <= waitLoad;
          lenCnt  <= patLen;
          lfsr    <= lfsr_next(lfsr);
        end
        ST_WAIT: begin
          if (!armEn)              state <= ST_IDLE;
          else if (waitCnt == '0)  state <= ST_INJ;
          else                     waitCnt <= waitCnt - 1'b1;
        end
        ST_INJ: begin
          if (!armEn)              state <= ST_IDLE;
          else if (lenCnt == '0)   state <= ST_DONE;
          else                     lenCnt <= lenCnt - 1'b1;
        end
        ST_DONE: if (!armEn) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = armTake;
    strobe.shift   = (state == ST_INJ) && armEn && (lenCnt != '0);
    strobe.active  = (state == ST_INJ);
  end

  assign injActive = strobe.active;
  assign injDone   = (state == ST_DONE);

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(injDone) |-> $past(injActive)); // R8
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(injActive && injDone)); // R8
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    !armEn |=> (!injActive && !injDone)); // R9
  AST_WAIT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (waitCnt <= CNT_MAX)); // R3
  AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    seeded |-> (lfsr != '0)); // R4

endmodule

// File: rtl/lfi_datapath.sv
module lfi_datapath
  import lfi_pkg::*;
#(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lfi_strobe_t      strobe,
  input  logic [PAT_W-1:0] patWord,
  input  logic             modeForce,
  input  logic             lineIn,
  output logic             lineOut
);

  logic [PAT_W-1:0] patShadow;
  logic             modeShadow;
  logic             injBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      patShadow  <= '0;
      modeShadow <= 1'b0;
    end else if (strobe.capture) begin
      patShadow  <= patWord;
      modeShadow <= modeForce;
    end else if (strobe.shift) begin
      patShadow  <= {1'b0, patShadow[PAT_W-1:1]};
    end
  end

  assign injBit = patShadow[0];

  // combinational bypass keeps the idle path free of registers
  always_comb begin
    if (!strobe.active)  lineOut = lineIn;
    else if (modeShadow) lineOut = injBit;
    else                 lineOut = lineIn ^ injBit;
  end

  AST_SHIFT_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.shift |-> strobe.active); // R5
  AST_NO_CAPTURE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.active |-> !strobe.capture); // R7

endmodule

// File: rtl/line_fault_injector.sv
module line_fault_injector
  import lfi_pkg::*;
#(
  parameter int CLK_NS    = 4,
  parameter int BOOT_NS   = 6500,
  parameter int WINDOW_NS = 15000,
  parameter int LEN_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lineIn,
  input  logic                  armEn,
  input  logic                  modeForce,
  input  logic [(1<<LEN_W)-1:0] patWord,
  input  logic [LEN_W-1:0]      patLen,
  input  logic [LFSR_W-1:0]     seed,
  output logic                  lineOut,
  output logic                  injActive,
  output logic                  injDone
);

  localparam int BOOT_TICKS = BOOT_NS / CLK_NS;
  localparam int SPAN       = WINDOW_NS / CLK_NS + 1;
  localparam int PAT_W      = 1 << LEN_W;

  lfi_strobe_t strobe;

  lfi_ctrl #(
    .BOOT_TICKS(BOOT_TICKS),
    .SPAN      (SPAN),
    .LEN_W     (LEN_W)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .armEn    (armEn),
    .seed     (seed),
    .patLen   (patLen),
    .strobe   (strobe),
    .injActive(injActive),
    .injDone  (injDone)
  );

  lfi_datapath #(
    .PAT_W(PAT_W)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .patWord  (patWord),
    .modeForce(modeForce),
    .lineIn   (lineIn),
    .lineOut  (lineOut)
  );

  AST_IDLE_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    !injActive |-> (lineOut == lineIn)); // R1

endmodule

// File: tb/line_fault_injector_tb_top.sv
module line_fault_injector_tb_top;

  localparam int BOOT = 1625;
  localparam int SPAN = 3751;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lineIn = 1'b0;
  logic        armEn = 1'b0;
  logic        modeForce = 1'b0;
  logic [15:0] patWord = '0;
  logic [3:0]  patLen = '0;
  logic [15:0] seed = '0;
  logic        lineOut, injActive, injDone;

  int checks = 0;
  int errors = 0;
  logic expQ[$];
  logic [15:0] model;

  always #2 clk = ~clk;

  line_fault_injector dut_i (
    .clk(clk), .rst_n(rst_n), .lineIn(lineIn), .armEn(armEn),
    .modeForce(modeForce), .patWord(patWord), .patLen(patLen), .seed(seed),
    .lineOut(lineOut), .injActive(injActive), .injDone(injDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] stepModel(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  // monitor: pops one expected wire value per burst cycle
  always @(negedge clk) begin
    if (rst_n && injActive) begin
      if (expQ.size() == 0) chk(1'b0, "R5 extra burst cycle", 1, 0);
      else begin
        logic e;
        e = expQ.pop_front();
        chk(lineOut === e, "R5 R6 burst value", int'(lineOut), int'(e));
      end
    end
  end

  task automatic resetDut(input logic [15:0] s);
    @(negedge clk);
    rst_n = 1'b0; armEn = 1'b0; seed = s;
    repeat (2) @(negedge clk);
    chk(!injActive && !injDone, "R10 outputs in reset", {injActive, injDone}, 0);
    lineIn = 1'b1; #1;
    chk(lineOut === 1'b1, "R10 wire in reset", int'(lineOut), 1);
    lineIn = 1'b0; #1;
    chk(lineOut === 1'b0, "R10 wire in reset", int'(lineOut), 0);
    @(negedge clk); rst_n = 1'b1;
    model = (s == 16'h0) ? 16'h1 : s;
    repeat (3) @(negedge clk);
  endtask

  task automatic runEvent(input logic [15:0] pat, input logic [3:0] len,
                          input logic mode, input logic lin);
    int expD;
    int n;
    expD = BOOT + int'(model % 16'(SPAN));
    model = stepModel(model);
    @(negedge clk);
    patWord = pat; patLen = len; modeForce = mode; lineIn = lin; armEn = 1'b1;
    for (int i = 0; i <= int'(len); i++) expQ.push_back(mode ? pat[i] : (lin ^ pat[i]));
    @(posedge clk);               // E0
    @(negedge clk);
    n = 1;
    patWord = ~pat; patLen = ~len; modeForce = ~mode;   // R7: late changes
    while (n <= 6000 && !injActive) begin
      if (n == 5) begin
        lineIn = ~lin; #1;
        chk(lineOut === ~lin, "R2 follow while waiting", int'(lineOut), int'(~lin));
        lineIn = lin;
      end
      n++;
      @(negedge clk);
    end
    chk(n == expD + 1, "R3 R4 burst start cycle", n, expD + 1);
    while (injActive) @(negedge clk);
    chk(expQ.size() == 0, "R5 R7 burst length", expQ.size(), 0);
    expQ.delete();
    chk(injDone === 1'b1, "R8 done after burst", int'(injDone), 1);
    lineIn = ~lin; #1;
    chk(lineOut === ~lin, "R2 follow after done", int'(lineOut), int'(~lin));
    n = 0;
    repeat (20) begin
      @(negedge clk);
      if (injActive || !injDone) n++;
    end
    chk(n == 0, "R8 single event while armed", n, 0);
    armEn = 1'b0;
    @(negedge clk);
    chk(injDone === 1'b0, "R9 done cleared", int'(injDone), 0);
  endtask

  task automatic cancelEvent();
    int bad;
    model = stepModel(model);
    @(negedge clk);
    patWord = 16'hFFFF; patLen = 4'd3; modeForce = 1'b1; lineIn = 1'b0; armEn = 1'b1;
    repeat (40) @(negedge clk);
    armEn = 1'b0;
    bad = 0;
    repeat (BOOT + 100) begin
      @(negedge clk);
      if (injActive || injDone || lineOut !== lineIn) bad++;
    end
    chk(bad == 0, "R9 cancel leaves wire alone", bad, 0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    resetDut(16'd100);
    lineIn = 1'b1; #1;
    chk(lineOut === 1'b1, "R1 idle pass-through", int'(lineOut), 1);
    lineIn = 1'b0; #1;
    chk(lineOut === 1'b0, "R1 idle pass-through", int'(lineOut), 0);
    runEvent(16'hA5C3, 4'd15, 1'b1, 1'b0);   // forced, full length, seed offset 100
    runEvent(16'h0F3A, 4'd7, 1'b0, 1'b1);    // XOR onto a high wire
    cancelEvent();
    runEvent(16'h0001, 4'd0, 1'b1, 1'b0);    // single-cycle burst
    resetDut(16'h0000);                      // zero seed acts as 1
    runEvent(16'h8421, 4'd9, 1'b0, 1'b0);
    resetDut(16'hFFFF);                      // largest seed
    runEvent(16'h3C3C, 4'd5, 1'b1, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule